// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block guards against runaway software. A counter advances on every E-clock enable pulse. If it reaches the programmed timeout before software services it, the block raises a reset request. Servicing takes two writes to one byte-wide service register, in order: first 0x55, which arms the clear, then 0xAA, which restarts the count. Writing 0xAA on its own does not service the timer. An unrelated stray write therefore cannot keep a broken program alive.

The timeout is a base interval of 2^BASE_LOG2 E cycles, multiplied by a factor that two rate bits select. The rate bits are read only during a short window after reset and cannot change after that. A disable input decides whether the watchdog runs. The block reads it once, on the first clock after reset is released. Changing it later has no effect until the next reset. The reset request stays asserted until the system reset arrives.

Top module: `keyed_wdt`

## Requirements
- R1: A write of 0x55 to the service register arms the clear. The next write of 0xAA while armed restarts the timeout count at zero and disarms the clear.
- R2: A write of 0xAA while not armed does not restart the count. The reset request comes at the same edge as if no write had happened.
- R3: Writes of any value other than 0x55 or 0xAA, placed between 0x55 and 0xAA, leave the arm state unchanged and do not restart the count.
- R4: Rate encodings 0, 1, 2 and 3 give multipliers 1, 4, 16 and 64. `resetReq` rises at the clock edge that carries the (2^BASE_LOG2 × multiplier)-th counted E tick after a restart. The first clock edge after reset counts no tick.
- R5: The count advances only on clock edges where `eTick` is 1.
- R6: `disableCfg` is sampled on the first clock edge after reset is released. With a value of 1 the block never requests reset. A later change has effect only after the next reset.
- R7: `rateSel` is sampled while fewer than WINDOW E ticks have occurred since reset. After that the selected timeout is fixed.
- R8: `resetReq` is 0 after reset. Once it is 1, it stays 1 until `rstN` is asserted.
- R9: A restarting 0xAA write that lands on the edge where the count would expire wins. The count restarts and no reset is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eTick | input | 1 | E-clock enable, one pulse per counted cycle |
| wrEn | input | 1 | Write strobe for the service register |
| wrData | input | 8 | Byte written to the service register |
| rateSel | input | 2 | Timeout multiplier select (0:×1, 1:×4, 2:×16, 3:×64) |
| disableCfg | input | 1 | 1 turns the watchdog off, sampled after reset |
| resetReq | output | 1 | Sticky system reset request |

## Verification
The assertions check on every cycle that the request is sticky, that the count holds still without a tick or a restart, that a restart zeroes it, that a disabled watchdog never requests reset, and that the rate stays frozen once the window closes. Only the bench's scenarios can show the exact expiry edge for each multiplier, the refusal of an unarmed 0xAA, tolerance of stray writes between the key bytes, the deferred effect of the disable input, and a restart winning over expiry on the same edge.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  typedef struct packed {
    logic kick;  // armed 0xAA write: restart the count
    logic tick;  // counted E cycle while enabled
  } wdtStrobe_t;
endpackage

// File: rtl/keyed_wdt_ctrl.sv
module keyed_wdt_ctrl
  import keyed_wdt_pkg::*;
#(
  parameter int RATE_W = 2,
  parameter int WINDOW = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eTick,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              disableCfg,
  output wdtStrobe_t        strb,
  output logic [RATE_W-1:0] rateReg,
  output logic              runEn
);
  localparam int WIN_W = $clog2(WINDOW + 1);

  logic             armed;
  logic             cfgDone;
  logic [WIN_W-1:0] winCnt;
  logic             winOpen;

  assign winOpen = (winCnt != WIN_W'(WINDOW));

  // Enable is latched once, on the first edge after reset release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgDone <= 1'b0;
      runEn   <= 1'b0;
    end else if (!cfgDone) begin
      cfgDone <= 1'b1;
      runEn   <= !disableCfg;
    end
  end

  // Rate follows the input only while the post-reset window is open
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt  <= '0;
      rateReg <= '0;
    end else if (winOpen) begin
      rateReg <= rateSel;
      if (eTick) winCnt <= winCnt + 1'b1;
    end
  end

  // Two-step key: 0x55 arms, 0xAA fires and disarms, others ignored
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (wrEn) begin
      if (wrData == KEY_ARM)       armed <= 1'b1;
      else if (wrData == KEY_FIRE) armed <= 1'b0;
    end
  end

  always_comb begin
    strb.kick = wrEn && (wrData == KEY_FIRE) && armed;
    strb.tick = eTick && runEn;
  end

  a_r1_arm_on_key: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData == KEY_ARM) |=> armed);

  a_r3_other_keeps_arm: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData != KEY_ARM && wrData != KEY_FIRE) |=> $stable(armed));

  a_r7_rate_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !winOpen |=> $stable(rateReg));
endmodule

// File: rtl/keyed_wdt_datapath.sv
module keyed_wdt_datapath
  import keyed_wdt_pkg::*;
#(
  parameter int BASE_LOG2  = 15,
  parameter int RATE_W     = 2,
  parameter int RATE_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdtStrobe_t        strb,
  input  logic [RATE_W-1:0] rateReg,
  output logic              expired
);
  localparam int MAX_SH = BASE_LOG2 + RATE_SHIFT * ((1 << RATE_W) - 1);
  localparam int CNT_W  = MAX_SH + 1;

  logic [CNT_W-1:0] cnt;
  logic [7:0]       shAmt;
  logic [CNT_W-1:0] lastVal;

  assign shAmt   = 8'(BASE_LOG2) + 8'(RATE_SHIFT) * 8'(rateReg);
  assign lastVal = (CNT_W'(1) << shAmt) - CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (!expired) begin
      if (strb.kick) begin
        cnt <= '0;
      end else if (strb.tick) begin
        if (cnt >= lastVal) expired <= 1'b1;
        else                cnt     <= cnt + 1'b1;
      end
    end
  end

  a_r1_kick_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    (strb.kick && !expired) |=> (cnt == '0));

  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.kick) |=> $stable(cnt));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    expired |=> expired);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int BASE_LOG2  = 15,
  parameter int RATE_SHIFT = 2,
  parameter int WINDOW     = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       eTick,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic [1:0] rateSel,
  input  logic       disableCfg,
  output logic       resetReq
);
  localparam int RATE_W = 2;

  wdtStrobe_t        strb;
  logic [RATE_W-1:0] rateReg;
  logic              runEn;

  keyed_wdt_ctrl #(.RATE_W(RATE_W), .WINDOW(WINDOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .eTick(eTick), .wrEn(wrEn), .wrData(wrData),
    .rateSel(rateSel), .disableCfg(disableCfg),
    .strb(strb), .rateReg(rateReg), .runEn(runEn)
  );

  keyed_wdt_datapath #(.BASE_LOG2(BASE_LOG2), .RATE_W(RATE_W), .RATE_SHIFT(RATE_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rateReg(rateReg), .expired(resetReq)
  );

  a_r6_disabled_silent: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !resetReq);
endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 4;
  localparam int WIN  = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eTick = 1'b1;
  logic wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [1:0] rateSel = 2'b00;
  logic disableCfg = 1'b0;
  logic resetReq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdt #(.BASE_LOG2(BASE), .RATE_SHIFT(2), .WINDOW(WIN)) u_dut (
    .clk(clk), .rstN(rstN), .eTick(eTick), .wrEn(wrEn), .wrData(wrData),
    .rateSel(rateSel), .disableCfg(disableCfg), .resetReq(resetReq)
  );

  // Behavioural reference model
  int mEn, mCfg, mArm, mCnt, mRate, mWin, mExp, edgeCnt;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mEn = 0; mCfg = 0; mArm = 0; mCnt = 0; mRate = 0; mWin = 0; mExp = 0; edgeCnt = 0;
    end else begin
      int oArm, oRate, oEn, lim;
      bit oOpen, kick;
      oArm = mArm; oRate = mRate; oEn = mEn; oOpen = (mWin < WIN);
      kick = wrEn && (wrData == 8'hAA) && (oArm != 0);
      lim = (1 << BASE) * (4 ** oRate);
      if (mExp == 0) begin
        if (kick) mCnt = 0;
        else if (eTick && oEn != 0) begin
          if (mCnt >= lim - 1) mExp = 1; else mCnt = mCnt + 1;
        end
      end
      if (wrEn && wrData == 8'h55) mArm = 1;
      else if (wrEn && wrData == 8'hAA) mArm = 0;
      if (mCfg == 0) begin mEn = disableCfg ? 0 : 1; mCfg = 1; end
      if (oOpen) begin mRate = rateSel; if (eTick) mWin = mWin + 1; end
      edgeCnt = edgeCnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (resetReq !== (mExp != 0)) begin
        errors++;
        $display("FAIL R4 model edge %0d act=%0b exp=%0b", edgeCnt, resetReq, mExp);
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic dis, input logic [1:0] rate);
    @(negedge clk);
    rstN = 1'b0; disableCfg = dis; rateSel = rate; wrEn = 1'b0; eTick = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 reset state", resetReq, 1'b0);
    rstN = 1'b1;
  endtask

  task automatic runTo(input int n);
    while (edgeCnt < n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 + R4: service restarts; expiry 16 ticks after the kick edge
    doReset(1'b0, 2'b00);
    runTo(5); wr(8'h55); wr(8'hAA);            // kick at edge 7
    runTo(22); chk("R1 no expiry before 16 ticks", resetReq, 1'b0);
    runTo(23); chk("R4 x1 expiry edge", resetReq, 1'b1);
    runTo(40); chk("R8 sticky", resetReq, 1'b1);

    // R2: unarmed 0xAA ignored, expiry at edge 17
    doReset(1'b0, 2'b00);
    runTo(3); wr(8'hAA);
    runTo(16); chk("R2 not yet", resetReq, 1'b0);
    runTo(17); chk("R2 unarmed AA no restart", resetReq, 1'b1);

    // R3: stray writes between keys; kick at edge 7, second AA unarmed
    doReset(1'b0, 2'b00);
    runTo(3); wr(8'h55); wr(8'h12); wr(8'h00); wr(8'hAA);
    wr(8'hAA);                                   // edge 8, disarmed: ignored
    runTo(22); chk("R3 stray writes kept arm", resetReq, 1'b0);
    runTo(23); chk("R3 expiry after kick", resetReq, 1'b1);

    // R4: rate 1 gives 64 ticks
    doReset(1'b0, 2'b01);
    runTo(64); chk("R4 x4 not yet", resetReq, 1'b0);
    runTo(65); chk("R4 x4 expiry edge", resetReq, 1'b1);

    // R5: no count without eTick
    doReset(1'b0, 2'b00);
    eTick = 1'b0;
    runTo(40); chk("R5 idle without tick", resetReq, 1'b0);
    eTick = 1'b1;
    runTo(55); chk("R5 15 ticks", resetReq, 1'b0);
    runTo(56); chk("R5 16th tick expires", resetReq, 1'b1);

    // R6: disabled at reset; later clearing has no effect until reset
    doReset(1'b1, 2'b00);
    runTo(1); disableCfg = 1'b0;
    runTo(2000); chk("R6 disabled stays silent", resetReq, 1'b0);
    doReset(1'b0, 2'b00);
    runTo(16); chk("R6 enabled after reset not yet", resetReq, 1'b0);
    runTo(17); chk("R6 enabled after reset expires", resetReq, 1'b1);

    // R7: rate 3 held through window, later change ignored
    doReset(1'b0, 2'b11);
    runTo(64); rateSel = 2'b00;
    runTo(200); chk("R7 rate change after window ignored", resetReq, 1'b0);
    runTo(1024); chk("R7 x64 not yet", resetReq, 1'b0);
    runTo(1025); chk("R7 x64 expiry edge", resetReq, 1'b1);

    // R9: kick on expiry edge wins
    doReset(1'b0, 2'b00);
    runTo(9); wr(8'h55);
    runTo(16); wr(8'hAA);                        // edge 17
    chk("R9 kick beats expiry", resetReq, 1'b0);
    runTo(32); chk("R9 restarted count", resetReq, 1'b0);
    runTo(33); chk("R9 later expiry", resetReq, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule